// File: doc/BRIEF.md
# Inter-Processor Interrupt Generation Registers

This block is a small register bank on a simple register bus. It lets any bus master send an interrupt to one of several processor cores (two by default) and mark why it did so. Each core owns one 32-bit generation register. Writing a one to bit 0 of that register sends a single-cycle pulse on that core's interrupt line. Bits 31..4 hold 28 sticky source flags. A write sets the flags at the positions where the data has ones.

Each core also has an acknowledge register at its own address. It reads back the same flag state as the generation register, and writing ones to it clears the matching flags. The target core's software uses it to retire the sources it has serviced.

Each core slot holds a two-state pulse machine. In PULSE_IDLE the interrupt line is low. A generate write moves it to PULSE_FIRE (transition IDLE→FIRE). PULSE_FIRE drives the line high for that one cycle, then returns to PULSE_IDLE (FIRE→IDLE). If a new generate write arrives while in PULSE_FIRE, the machine stays in PULSE_FIRE (FIRE→FIRE), which gives back-to-back pulses. With no generate write, PULSE_IDLE stays in PULSE_IDLE (IDLE→IDLE).

Top module: `ipi_gen_bank`

## Requirements
- R1: After reset, every flag is 0, every `irq_pulse` bit is 0, and reads of offsets 0x0, 0x4, 0x8 and 0xC return 0.
- R2: A write with data bit 0 = 1 to offset 0x0 (core 0) or 0x4 (core 1) drives that core's `irq_pulse` bit high for exactly one clock, in the cycle after the write edge.
- R3: A write to a generation register with data bit 0 = 0 produces no pulse. A write to an acknowledge register never produces a pulse, whatever its bit 0 is.
- R4: Generate writes on consecutive cycles give pulses on consecutive cycles.
- R5: Read data bits 3..0 are always 0, whatever was written to them.
- R6: Writing to a generation register sets the flags where data bits 31..4 are 1 (flag n sits at bit n+4). Data bits that are 0 leave their flags unchanged.
- R7: Writing to an acknowledge register (0x8 for core 0, 0xC for core 1) clears the flags where data bits 31..4 are 1. Other flags are unchanged.
- R8: Reading a core's acknowledge register returns the same value as reading its generation register.
- R9: A write to one core's registers changes neither the flags nor the pulse of the other core.
- R10: Accesses to offsets that are not word-aligned, or that are 0x10 and above, read 0 and change no flag and no pulse.
- R11: `bus_rdata` is combinational from the current flag state while `bus_re` is high, and is 0 while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, same cycle as `bus_re` |
| irq_pulse | output | 2 | One interrupt pulse line per core |

## Verification
The hardest case to reach from the ports is the FIRE→FIRE transition. To reach it, two generate writes must land on adjacent edges with no idle cycle between them, so the line stays high for two cycles instead of returning low. The driver issues one bus operation per clock without gaps, which makes that sequence easy to produce. A scoreboard queue holds the pulse vector expected for every cycle, so a missing, stretched or misrouted pulse shows up in the exact cycle where it occurs. Acknowledge writes carrying bit 0 = 1, and writes to misaligned and out-of-range offsets, are interleaved with flag reads to show that these accesses change nothing.

// File: rtl/ipi_gen_pkg.sv
package ipi_gen_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned FLAG_LSB  = 4;
    localparam int unsigned NUM_FLAGS = DATA_W - FLAG_LSB;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_FIRE = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
    parameter int unsigned NUM_CORES = 2,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CORES-1:0] gen_hit,
    output logic [NUM_CORES-1:0] ack_hit
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_hit
        assign gen_hit[c] = aligned && (word_idx == WORD_W'(c));
        assign ack_hit[c] = aligned && (word_idx == WORD_W'(NUM_CORES + c));
    end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_gen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gen_wr,
    input  logic                 ack_wr,
    input  logic                 go_bit,
    input  logic [NUM_FLAGS-1:0] mask,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);
    pulse_state_e          state_q, state_d;
    logic                  fire_req;
    logic [NUM_FLAGS-1:0]  set_mask, clr_mask, flags_d;

    assign fire_req = gen_wr && go_bit;
    assign set_mask = gen_wr ? mask : '0;
    assign clr_mask = ack_wr ? mask : '0;
    // set wins over a clear in the same cycle
    assign flags_d  = (flags & ~clr_mask) | set_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE: state_d = fire_req ? PULSE_FIRE : PULSE_IDLE;
            PULSE_FIRE: state_d = fire_req ? PULSE_FIRE : PULSE_IDLE;
            default:    state_d = PULSE_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == PULSE_FIRE);
    end

    // R2
    pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_req |=> irq);
    // R3
    no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_req |=> !irq);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_wr |=> ((flags & $past(mask)) == $past(mask)));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !gen_wr) |=> ((flags & $past(mask)) == '0));
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_wr && !ack_wr) |=> $stable(flags));
endmodule

// File: rtl/ipi_gen_bank.sv
module ipi_gen_bank
    import ipi_gen_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_re,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq_pulse
);
    logic [NUM_CORES-1:0]                gen_hit, ack_hit;
    logic [NUM_CORES-1:0][NUM_FLAGS-1:0] core_flags;
    logic                                unused_rsvd;

    assign unused_rsvd = ^bus_wdata[FLAG_LSB-1:1];

    ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .gen_hit (gen_hit),
        .ack_hit (ack_hit)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ipi_core_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .gen_wr (bus_we && gen_hit[c]),
            .ack_wr (bus_we && ack_hit[c]),
            .go_bit (bus_wdata[0]),
            .mask   (bus_wdata[DATA_W-1:FLAG_LSB]),
            .flags  (core_flags[c]),
            .irq    (irq_pulse[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (bus_re && (gen_hit[c] || ack_hit[c]))
                bus_rdata = {core_flags[c], {FLAG_LSB{1'b0}}};
        end
    end

    // R10
    decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gen_hit, ack_hit}));
endmodule

// File: tb/ipi_gen_bank_tb.sv
module ipi_gen_bank_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] irq;
        string      req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_pulse;

    int          checks = 0;
    int          errors = 0;
    bit          running = 1'b0;
    bit          finished = 1'b0;
    logic [27:0] model_flags [2];
    exp_item_t   exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_gen_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one bus operation per clock, pushes expected pulse vector
    task automatic bus_op(input logic we, input logic re, input logic [5:0] a,
                          input logic [31:0] d, input string req);
        exp_item_t it;
        int        word;
        bit        aligned;
        logic [31:0] exp_rd;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        word = int'(a[5:2]);
        aligned = (a[1:0] == 2'b00);
        it.irq = 2'b00;
        it.req = req;
        if (we && aligned && word < 2 && d[0]) it.irq[word] = 1'b1;
        exp_q.push_back(it);
        #1;
        exp_rd = '0;
        if (re && aligned && word < 4) exp_rd = {model_flags[word % 2], 4'b0};
        check32(req, bus_rdata, exp_rd);
        if (we && aligned && word < 2)      model_flags[word] = model_flags[word] | d[31:4];
        else if (we && aligned && word < 4) model_flags[word-2] = model_flags[word-2] & ~d[31:4];
    endtask

    task automatic idle(input string req);
        bus_op(1'b0, 1'b0, 6'h0, 32'h0, req);
    endtask

    // monitor: compares pulse lines once per cycle after the edge
    always @(posedge clk) begin
        exp_item_t it;
        #2;
        if (running && exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (irq_pulse !== it.irq) begin
                errors++;
                $display("FAIL %s irq actual=%b expected=%b", it.req, irq_pulse, it.irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_flags[0] = '0;
        model_flags[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        running = 1'b1;
        // R1: reset state
        check32("R1", {30'b0, irq_pulse}, 32'h0);
        bus_op(0, 1, 6'h00, 0, "R1");
        bus_op(0, 1, 6'h04, 0, "R1");
        bus_op(0, 1, 6'h08, 0, "R1");
        bus_op(0, 1, 6'h0C, 0, "R1");
        // R2 / R9: pulse to core 1 only, one cycle wide
        bus_op(1, 0, 6'h04, 32'h1, "R2");
        idle("R2");
        idle("R2");
        bus_op(1, 0, 6'h00, 32'h1, "R9");
        idle("R9");
        // R3: no pulse on bit0=0, none from acknowledge writes
        bus_op(1, 0, 6'h00, 32'h0, "R3");
        bus_op(1, 0, 6'h08, 32'h1, "R3");
        bus_op(1, 0, 6'h0C, 32'h1, "R3");
        idle("R3");
        // R4: back-to-back pulses
        bus_op(1, 0, 6'h00, 32'h1, "R4");
        bus_op(1, 0, 6'h00, 32'h1, "R4");
        bus_op(1, 0, 6'h04, 32'h1, "R4");
        idle("R4");
        idle("R4");
        // R6: set flags, accumulate
        bus_op(1, 0, 6'h00, 32'h0000_00F0, "R6");
        bus_op(1, 0, 6'h00, 32'h0000_0F00, "R6");
        bus_op(0, 1, 6'h00, 0, "R6");
        // R5: reserved bits read zero
        bus_op(1, 0, 6'h00, 32'h8000_000E, "R5");
        bus_op(0, 1, 6'h00, 0, "R5");
        // R8: acknowledge register mirrors flags
        bus_op(0, 1, 6'h08, 0, "R8");
        // R9: core 1 untouched
        bus_op(0, 1, 6'h04, 0, "R9");
        // R7: clear via acknowledge
        bus_op(1, 0, 6'h08, 32'h8000_0030, "R7");
        bus_op(0, 1, 6'h00, 0, "R7");
        bus_op(1, 0, 6'h04, 32'hF000_0010, "R7");
        bus_op(1, 0, 6'h0C, 32'h7000_0000, "R7");
        bus_op(0, 1, 6'h0C, 0, "R7");
        bus_op(0, 1, 6'h00, 0, "R9");
        // R10: unmapped offsets
        bus_op(1, 0, 6'h10, 32'hFFFF_FFFF, "R10");
        bus_op(1, 0, 6'h02, 32'hFFFF_FFFF, "R10");
        bus_op(1, 0, 6'h3C, 32'hFFFF_FFFF, "R10");
        bus_op(0, 1, 6'h10, 0, "R10");
        bus_op(0, 1, 6'h01, 0, "R10");
        bus_op(0, 1, 6'h00, 0, "R10");
        bus_op(0, 1, 6'h04, 0, "R10");
        // R11: read enable low gives zero
        bus_op(0, 0, 6'h00, 0, "R11");
        bus_op(0, 0, 6'h04, 0, "R11");
        idle("R11");
        idle("R11");
        @(negedge clk);
        bus_we = 0; bus_re = 0;
        repeat (2) @(posedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule